// File: doc/BRIEF.md
# Dual-Core Reset Distribution Controller

This block collects reset request pulses from every reset cause in a two-core system and fans them out to five reset outputs: the application CPU, the application watchdog, the debug domain, the network CPU and the network watchdog. A fixed map, held in a package function, decides which targets each cause reaches. The power-on reset is the active-low asynchronous input `por_n`. The other causes arrive as one-cycle pulses on `req_i`, synchronous to `clk`.

Any reset on the application side also sets a network force-off flag. While the flag is set, the network CPU and the network watchdog stay in reset and `net_pwr_off_o` asks for the network power and clock to be gated. Only application software can release the flag, through a small write port. Writes that come from the network core are dropped.

While `dbg_mode_i` is high, lockup requests from either core are ignored and the debug domain is never reset. Each reset output rises in the same cycle as its cause, without waiting for a clock edge. It falls on a clock edge once `HOLD_CYC` cycles have passed with no further cause.

Top module: `reset_fanout`

## Requirements
- R1: While `por_n` is low, all five reset outputs and `net_pwr_off_o` are high. After `por_n` rises, the outputs stay high through the third falling clock edge. At the fourth falling clock edge the application and debug outputs are low. The force-off flag is still set at that point, so the network outputs stay high.
- R2: The request bit positions are: `req_i[0]` brownout, `[1]` pin, `[2]` wake from System OFF, `[3]` application soft reset, `[4]` application debug-port reset, `[5]` application lockup, `[6]` application watchdog, `[7]` network soft reset, `[8]` network debug-port reset, `[9]` network lockup, `[10]` network watchdog.
- R3: A brownout, pin or wake request asserts all five reset outputs and sets the force-off flag.
- R4: An application soft, debug-port or lockup request does three things:
  - it asserts the application CPU reset;
  - it sets the force-off flag, which resets the network CPU and network watchdog;
  - it leaves the application watchdog and debug outputs low.
- R5: An application watchdog request does two things:
  - it asserts the application CPU, application watchdog and debug resets;
  - it sets the force-off flag.
- R6: The force-off flag is set at reset and by any application-side request. It is held until an application-port write of 0 to bit 0 (`wr_data_i`) at address `FO_ADDR` (default 0x010). A write of 1 to that address sets the flag. While the flag is set, `net_pwr_off_o`, the network CPU reset and the network watchdog reset are high. A request that sets the flag wins over a release write in the same cycle.
- R7: Writes with `wr_from_net_i` high, and writes to any address other than `FO_ADDR`, leave the force-off flag unchanged.
- R8: A network soft, debug-port or lockup request asserts only the network CPU reset. A network watchdog request asserts the network CPU and network watchdog resets. Neither touches the application outputs or the force-off flag.
- R9: While `dbg_mode_i` is high, lockup requests from either core produce no reset, and no request asserts the debug reset.
- R10: A reset output rises in the same cycle as the request that causes it. It stays high for `HOLD_CYC` (default 4) clock cycles after the request cycle, and then falls on a rising clock edge.
- R11: A new request during a hold window restarts the window, so the output stays high for `HOLD_CYC` cycles after the latest request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all reset domains |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| req_i | input | 11 | Reset request pulses, one bit per cause |
| dbg_mode_i | input | 1 | Debug interface mode is active |
| wr_en_i | input | 1 | Register write strobe |
| wr_from_net_i | input | 1 | The write comes from the network core |
| wr_addr_i | input | ADDR_W | Register write address |
| wr_data_i | input | 1 | Force-off value to write (1 hold, 0 release) |
| app_cpu_rst_o | output | 1 | Application CPU reset |
| app_wdt_rst_o | output | 1 | Application watchdog reset |
| dbg_rst_o | output | 1 | Debug domain reset |
| net_cpu_rst_o | output | 1 | Network CPU reset |
| net_wdt_rst_o | output | 1 | Network watchdog reset |
| net_pwr_off_o | output | 1 | Gate network power and clock |

## Verification
An error in the source map shows at the ports in the request cycle itself, because the outputs follow the decoded request combinationally. A wrong target is therefore visible before any clock edge. A wrong hold counter shows only at the end of the window: an output falls one or more edges early, or fails to fall at the expected edge. A wrong force-off flag stays visible for as long as the flag keeps its value. The network outputs and `net_pwr_off_o` then disagree with the expected state on every later cycle, until the next write or application reset changes the flag.

// File: rtl/rstd_pkg.sv
package rstd_pkg;
  localparam int NUM_SRC = 11;
  localparam int NUM_TGT = 5;

  // request bit positions
  localparam int S_BOR   = 0;
  localparam int S_PIN   = 1;
  localparam int S_WAKE  = 2;
  localparam int S_ASOFT = 3;
  localparam int S_ADAP  = 4;
  localparam int S_ALOCK = 5;
  localparam int S_AWDT  = 6;
  localparam int S_NSOFT = 7;
  localparam int S_NDAP  = 8;
  localparam int S_NLOCK = 9;
  localparam int S_NWDT  = 10;

  // target bit positions
  localparam int T_ACPU = 0;
  localparam int T_AWDT = 1;
  localparam int T_DBG  = 2;
  localparam int T_NCPU = 3;
  localparam int T_NWDT = 4;

  typedef struct packed {
    logic [NUM_TGT-1:0] tgt;
    logic               fo;
  } src_map_t;

  // fixed cause-to-target map
  function automatic src_map_t map_source(input int idx);
    src_map_t m;
    m = '0;
    case (idx)
      S_BOR, S_PIN, S_WAKE: begin
        m.tgt = '1;
        m.fo  = 1'b1;
      end
      S_ASOFT, S_ADAP, S_ALOCK: begin
        m.tgt[T_ACPU] = 1'b1;
        m.fo          = 1'b1;
      end
      S_AWDT: begin
        m.tgt[T_ACPU] = 1'b1;
        m.tgt[T_AWDT] = 1'b1;
        m.tgt[T_DBG]  = 1'b1;
        m.fo          = 1'b1;
      end
      S_NSOFT, S_NDAP, S_NLOCK: m.tgt[T_NCPU] = 1'b1;
      S_NWDT: begin
        m.tgt[T_NCPU] = 1'b1;
        m.tgt[T_NWDT] = 1'b1;
      end
      default: m = '0;
    endcase
    return m;
  endfunction

  function automatic logic is_lockup(input int idx);
    return (idx == S_ALOCK) || (idx == S_NLOCK);
  endfunction

  function automatic logic is_net_target(input int t);
    return (t == T_NCPU) || (t == T_NWDT);
  endfunction
endpackage

// File: rtl/rstd_decode.sv
module rstd_decode
  import rstd_pkg::*;
(
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               dbg_mode_i,
  output logic [NUM_TGT-1:0] hit_o,
  output logic               set_fo_o
);
  always_comb begin
    src_map_t m;
    hit_o    = '0;
    set_fo_o = 1'b0;
    for (int i = 0; i < NUM_SRC; i++) begin
      m = map_source(i);
      if (req_i[i] && !(dbg_mode_i && is_lockup(i))) begin
        hit_o    = hit_o | m.tgt;
        set_fo_o = set_fo_o | m.fo;
      end
    end
    if (dbg_mode_i) hit_o[T_DBG] = 1'b0;
  end
endmodule

// File: rtl/rstd_stretch.sv
module rstd_stretch #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic por_n,
  input  logic trig_i,
  output logic rst_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] HOLD_V = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          cnt_q <= HOLD_V;
    else if (trig_i)     cnt_q <= HOLD_V;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  // rises without a clock, falls on an edge
  assign rst_o = !por_n || trig_i || (cnt_q != '0);
endmodule

// File: rtl/rstd_forceoff.sv
module rstd_forceoff #(
  parameter int              ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] FO_ADDR = 'h010
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              set_fo_i,
  input  logic              wr_en_i,
  input  logic              wr_from_net_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic              wr_data_i,
  output logic              fo_q_o
);
  logic wr_hit;
  assign wr_hit = wr_en_i && !wr_from_net_i && (wr_addr_i == FO_ADDR);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        fo_q_o <= 1'b1;
    else if (set_fo_i) fo_q_o <= 1'b1;
    else if (wr_hit)   fo_q_o <= wr_data_i;
  end
endmodule

// File: rtl/reset_fanout.sv
module reset_fanout
  import rstd_pkg::*;
#(
  parameter int              HOLD_CYC = 4,
  parameter int              ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] FO_ADDR  = 'h010
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic [NUM_SRC-1:0] req_i,
  input  logic               dbg_mode_i,
  input  logic               wr_en_i,
  input  logic               wr_from_net_i,
  input  logic [ADDR_W-1:0]  wr_addr_i,
  input  logic               wr_data_i,
  output logic               app_cpu_rst_o,
  output logic               app_wdt_rst_o,
  output logic               dbg_rst_o,
  output logic               net_cpu_rst_o,
  output logic               net_wdt_rst_o,
  output logic               net_pwr_off_o
);
  logic [NUM_TGT-1:0] hit;
  logic               set_fo;
  logic               fo_q;
  logic               fo_now;
  logic [NUM_TGT-1:0] trig;
  logic [NUM_TGT-1:0] rst_vec;

  rstd_decode u_decode (
    .req_i      (req_i),
    .dbg_mode_i (dbg_mode_i),
    .hit_o      (hit),
    .set_fo_o   (set_fo)
  );

  rstd_forceoff #(.ADDR_W(ADDR_W), .FO_ADDR(FO_ADDR)) u_fo (
    .clk           (clk),
    .por_n         (por_n),
    .set_fo_i      (set_fo),
    .wr_en_i       (wr_en_i),
    .wr_from_net_i (wr_from_net_i),
    .wr_addr_i     (wr_addr_i),
    .wr_data_i     (wr_data_i),
    .fo_q_o        (fo_q)
  );

  assign fo_now = fo_q || set_fo;

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    if (is_net_target(t)) begin : g_net
      assign trig[t] = hit[t] || fo_now;
    end else begin : g_app
      assign trig[t] = hit[t];
    end
    rstd_stretch #(.HOLD_CYC(HOLD_CYC)) u_str (
      .clk    (clk),
      .por_n  (por_n),
      .trig_i (trig[t]),
      .rst_o  (rst_vec[t])
    );
  end

  assign app_cpu_rst_o = rst_vec[T_ACPU];
  assign app_wdt_rst_o = rst_vec[T_AWDT];
  assign dbg_rst_o     = rst_vec[T_DBG];
  assign net_cpu_rst_o = rst_vec[T_NCPU];
  assign net_wdt_rst_o = rst_vec[T_NWDT];
  assign net_pwr_off_o = fo_now;
endmodule

// File: rtl/reset_fanout_chk.sv
module reset_fanout_chk
  import rstd_pkg::*;
(
  input logic               clk,
  input logic               por_n,
  input logic [NUM_SRC-1:0] req_i,
  input logic               dbg_mode_i,
  input logic               wr_en_i,
  input logic               wr_from_net_i,
  input logic [NUM_TGT-1:0] hit,
  input logic               set_fo,
  input logic               app_cpu_rst_o,
  input logic               dbg_rst_o,
  input logic               net_cpu_rst_o,
  input logic               net_wdt_rst_o,
  input logic               net_pwr_off_o
);
  // R10
  hold_app_cpu_chk: assert property (@(posedge clk) disable iff (!por_n)
    hit[T_ACPU] |=> app_cpu_rst_o);

  // R10
  hold_dbg_chk: assert property (@(posedge clk) disable iff (!por_n)
    hit[T_DBG] |=> dbg_rst_o);

  // R6
  fo_latch_chk: assert property (@(posedge clk) disable iff (!por_n)
    set_fo |=> net_pwr_off_o);

  // R6
  fo_holds_net_chk: assert property (@(posedge clk) disable iff (!por_n)
    net_pwr_off_o |-> (net_cpu_rst_o && net_wdt_rst_o));

  // R9
  dbg_spared_chk: assert property (@(posedge clk) disable iff (!por_n)
    dbg_mode_i |-> !hit[T_DBG]);

  // R7
  net_write_ignored_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en_i && wr_from_net_i && net_pwr_off_o) |=> net_pwr_off_o);

  // R8
  net_local_chk: assert property (@(posedge clk) disable iff (!por_n)
    (req_i[S_AWDT:S_BOR] == '0) |-> (!hit[T_ACPU] && !set_fo));

  // R4
  app_soft_scope_chk: assert property (@(posedge clk) disable iff (!por_n)
    (req_i == (NUM_SRC'(1) << S_ASOFT)) |-> (set_fo && !hit[T_AWDT] && !hit[T_DBG]));
endmodule

bind reset_fanout reset_fanout_chk i_chk (
  .clk           (clk),
  .por_n         (por_n),
  .req_i         (req_i),
  .dbg_mode_i    (dbg_mode_i),
  .wr_en_i       (wr_en_i),
  .wr_from_net_i (wr_from_net_i),
  .hit           (hit),
  .set_fo        (set_fo),
  .app_cpu_rst_o (app_cpu_rst_o),
  .dbg_rst_o     (dbg_rst_o),
  .net_cpu_rst_o (net_cpu_rst_o),
  .net_wdt_rst_o (net_wdt_rst_o),
  .net_pwr_off_o (net_pwr_off_o)
);

// File: tb/test_reset_fanout.sv
module test_reset_fanout;
  localparam int NSRC = 11;
  localparam int AW   = 12;
  localparam logic [AW-1:0] FOA = 12'h010;

  logic            clk = 1'b0;
  logic            por_n = 1'b0;
  logic [NSRC-1:0] req = '0;
  logic            dbg = 1'b0;
  logic            wr_en = 1'b0;
  logic            wr_net = 1'b0;
  logic [AW-1:0]   wr_addr = '0;
  logic            wr_data = 1'b0;
  logic a_cpu, a_wdt, d_rst, n_cpu, n_wdt, pwr_off;

  int runs = 0;
  int fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  reset_fanout i_reset_fanout (
    .clk(clk), .por_n(por_n), .req_i(req), .dbg_mode_i(dbg),
    .wr_en_i(wr_en), .wr_from_net_i(wr_net), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .app_cpu_rst_o(a_cpu), .app_wdt_rst_o(a_wdt), .dbg_rst_o(d_rst),
    .net_cpu_rst_o(n_cpu), .net_wdt_rst_o(n_wdt), .net_pwr_off_o(pwr_off)
  );

  // {fo, mask[4:0] = nwdt,ncpu,dbg,awdt,acpu, dbg, src[3:0]}
  localparam logic [10:0] VEC [16] = '{
    {1'b1, 5'b11111, 1'b0, 4'd0},
    {1'b1, 5'b11011, 1'b1, 4'd0},
    {1'b1, 5'b11111, 1'b0, 4'd1},
    {1'b1, 5'b11111, 1'b0, 4'd2},
    {1'b1, 5'b11011, 1'b1, 4'd2},
    {1'b1, 5'b11001, 1'b0, 4'd3},
    {1'b1, 5'b11001, 1'b0, 4'd4},
    {1'b1, 5'b11001, 1'b0, 4'd5},
    {1'b0, 5'b00000, 1'b1, 4'd5},
    {1'b1, 5'b11111, 1'b0, 4'd6},
    {1'b1, 5'b11011, 1'b1, 4'd6},
    {1'b0, 5'b01000, 1'b0, 4'd7},
    {1'b0, 5'b01000, 1'b0, 4'd8},
    {1'b0, 5'b01000, 1'b0, 4'd9},
    {1'b0, 5'b00000, 1'b1, 4'd9},
    {1'b0, 5'b11000, 1'b0, 4'd10}
  };

  function automatic string tag_of(input int src, input bit dm);
    if (dm) return "R9";
    if (src <= 2) return "R3";
    if (src <= 5) return "R4";
    if (src == 6) return "R5";
    return "R8";
  endfunction

  function automatic logic [4:0] outs();
    return {n_wdt, n_cpu, d_rst, a_wdt, a_cpu};
  endfunction

  task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic write_reg(input logic from_net, input logic [AW-1:0] a, input logic d);
    @(negedge clk);
    wr_en = 1'b1; wr_net = from_net; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_net = 1'b0;
  endtask

  task automatic release_fo();
    write_reg(1'b0, FOA, 1'b0);
    repeat (6) @(negedge clk);
  endtask

  task automatic pulse(input int src);
    @(negedge clk);
    req[src] = 1'b1;
    @(negedge clk);
    req = '0;
  endtask

  initial begin
    #150000;
    if (!done) begin
      fails++;
      runs++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    #20;
    check("R1 during reset", {pwr_off, outs()}, 6'b111111);
    @(negedge clk); por_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 hold after release", {pwr_off, outs()}, 6'b111111);
    @(negedge clk);
    check("R1 app side released", {pwr_off, outs()}, 6'b111000);

    // R6: release
    release_fo();
    check("R6 release", {pwr_off, outs()}, 6'b000000);

    // table walk (R2 bit positions via every index)
    for (int v = 0; v < 16; v++) begin
      int         src;
      bit         dm;
      logic [4:0] m;
      logic       f;
      src = int'(VEC[v][3:0]);
      dm  = VEC[v][4];
      m   = VEC[v][9:5];
      f   = VEC[v][10];
      release_fo();
      @(negedge clk);
      dbg = dm;
      @(negedge clk);
      req[src] = 1'b1;
      #1;
      check($sformatf("%s R10 same-cycle src%0d", tag_of(src, dm), src), {pwr_off, outs()}, {f, m});
      @(negedge clk);
      req = '0;
      check($sformatf("%s src%0d cycle1", tag_of(src, dm), src), {pwr_off, outs()}, {f, m});
      repeat (3) @(negedge clk);
      check($sformatf("R10 src%0d last hold cycle", src), {pwr_off, outs()}, {f, m});
      @(negedge clk);
      check($sformatf("R10 src%0d after hold", src), {pwr_off, outs()}, {f, f ? 5'b11000 : 5'b00000});
      dbg = 1'b0;
    end

    // R7: writes from the network core or to another address are ignored
    release_fo();
    pulse(3);
    repeat (6) @(negedge clk);
    write_reg(1'b1, FOA, 1'b0);
    repeat (6) @(negedge clk);
    check("R7 net-side write ignored", {pwr_off, outs()}, 6'b111000);
    write_reg(1'b0, FOA + 12'h4, 1'b0);
    repeat (6) @(negedge clk);
    check("R7 other address ignored", {pwr_off, outs()}, 6'b111000);
    release_fo();
    check("R6 app release", {pwr_off, outs()}, 6'b000000);
    write_reg(1'b0, FOA, 1'b1);
    check("R6 write 1 holds", {pwr_off, n_cpu, n_wdt}, 3'b111);
    release_fo();

    // R6: set wins over same-cycle release
    @(negedge clk);
    req[4] = 1'b1; wr_en = 1'b1; wr_addr = FOA; wr_data = 1'b0;
    @(negedge clk);
    req = '0; wr_en = 1'b0;
    repeat (6) @(negedge clk);
    check("R6 set beats release", {pwr_off, outs()}, 6'b111000);
    release_fo();

    // R11: retrigger restarts the window
    @(negedge clk); req[7] = 1'b1;
    @(negedge clk); req = '0;
    @(negedge clk); req[7] = 1'b1;
    @(negedge clk); req = '0;
    repeat (3) @(negedge clk);
    check("R11 extended hold", {pwr_off, outs()}, 6'b001000);
    @(negedge clk);
    check("R11 end of extended hold", {pwr_off, outs()}, 6'b000000);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule